// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the command words written to a word-wide NOR flash array model. It also chooses where later reads come from. A write cycle carries an 8-bit command and a word address. The controller keeps one of three read sources selected: the memory array, the identification codes, or the status register. That source stays selected until a different valid command arrives.

Block erase takes two writes: a setup word followed by a confirm word. The confirm address chooses the block. A cycle-counting write machine then runs the erase, and the erase can be paused and restarted.

Failure conditions set sticky bits in the status register. Only an explicit clear command removes them, and that command is refused while an erase is paused. The array is a small register memory. Each word holds a fixed pattern after reset, so the effect of an erase can be seen. Analog voltages and real cell timing are not modelled.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read source is the array, and every word reads `INIT_WORD` (0x1234 by default). While `pwrdn` is high the source is forced to the array and writes are ignored. After `pwrdn` falls, reads still come from the array.
- R2: The selected read source stays the same across any number of reads, until a valid command changes it.
- R3: Command 0xFF selects array reads. It is ignored while an erase is running and not paused, and it is accepted while the erase is paused.
- R4: Command 0x90 selects identification reads. Word address 0 returns 0x00B0 and word address 1 returns 0x0050.
- R5: In identification reads, offset 2 within a block returns that block's lock flag on bit 0 (1 = locked). Offset 3 returns the permanent lock flag on bit 0. Bits 15..1 read 0. Addresses are split into a block index (upper bits) and an offset (lower `BLK_W` bits).
- R6: Status bits 5, 4 and 1 are sticky. They survive other commands and are cleared only by command 0x50.
- R7: Command 0x50 has no effect while an erase is paused.
- R8: Command 0x20 followed immediately by 0xD0 erases the block addressed by the 0xD0 cycle. When the erase finishes, every word of that block reads 0xFFFF and other blocks are unchanged. Both cycles select status reads.
- R9: If the write after 0x20 is not 0xD0, no erase starts. Status bits 5 and 4 are set and status reads are selected.
- R10: The status value is captured on the first clock edge after `rd_n` falls. It stays frozen while `rd_n` stays low.
- R11: Status bit 7 is 1 when the write machine is ready and 0 while it is erasing. Command 0xB0 pauses a running erase: bit 6 becomes 1, bit 7 reads 1 and the erase timer stops. Command 0xD0 resumes a paused erase. Unused status bits read 0.
- R12: An erase aimed at a locked block sets status bit 1 and leaves the block's contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn | input | 1 | Deep power-down request; forces array reads and blocks writes |
| wr_en | input | 1 | One-cycle write strobe for a command |
| wr_cmd | input | 8 | Command word |
| addr | input | AW | Word address for commands and reads |
| rd_n | input | 1 | Active-low read strobe; its falling edge captures status |
| rdata | output | 16 | Read data from the selected source |

## Verification
The hardest state to reach is a paused erase that already carries sticky errors. The clear command must bounce off it, the array command must be accepted, and the erase must then finish correctly after it resumes.

The stimulus first builds the errors, using a broken setup sequence and an erase aimed at a locked block. It then starts a real erase and pauses it within a few cycles, well before the timer can expire. It waits far longer than the erase duration to show the timer is frozen, then resumes the erase.

A separate read holds `rd_n` low across a whole erase, to show that the captured status does not follow the live one.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_RD_IDENT = 8'h90;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_ER_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND  = 8'hB0;

    localparam logic [15:0] ID_MAKER  = 16'h00B0;
    localparam logic [15:0] ID_DEVICE = 16'h0050;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_STATUS = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic erase_fail;
        logic seq_fail;
        logic volt_fail;
        logic lock_fail;
    } sticky_t;

    function automatic logic [7:0] pack_status(input logic ready,
                                               input logic paused,
                                               input sticky_t s);
        return {ready, paused, s.erase_fail, s.seq_fail, s.volt_fail,
                1'b0, s.lock_fail, 1'b0};
    endfunction

endpackage

// File: rtl/fcmd_wsm.sv
module fcmd_wsm
    import fcmd_pkg::*;
#(
    parameter int ERASE_CYC = 40,
    parameter int BIW       = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [BIW-1:0] start_blk,
    input  logic           pause_req,
    input  logic           resume_req,
    output logic           running,
    output logic           paused,
    output logic           done,
    output logic [BIW-1:0] done_blk
);
    localparam int CW = (ERASE_CYC > 2) ? $clog2(ERASE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(ERASE_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            paused   <= 1'b0;
            done     <= 1'b0;
            cnt      <= '0;
            done_blk <= '0;
        end else begin
            done <= 1'b0;
            if (start && !running) begin
                running  <= 1'b1;
                paused   <= 1'b0;
                cnt      <= '0;
                done_blk <= start_blk;
            end else if (running) begin
                if (paused) begin
                    if (resume_req) paused <= 1'b0;
                end else if (pause_req) begin
                    paused <= 1'b1;
                end else if (cnt == LAST) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_PAUSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        paused |-> running);                                          // R11
    AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (paused && !resume_req) |=> $stable(cnt));                    // R11
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> (!running && $past(running)));                       // R8

endmodule

// File: rtl/fcmd_store.sv
module fcmd_store
    import fcmd_pkg::*;
#(
    parameter int AW                 = 6,
    parameter int BLK_W              = 4,
    parameter logic [15:0] INIT_WORD = 16'h1234,
    parameter int NBLK               = 4,
    parameter logic [NBLK-1:0] LOCK_INIT = 4'b0010
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      erase_go,
    input  logic [AW-BLK_W-1:0]       erase_blk,
    input  logic [AW-1:0]             rd_addr,
    output logic [15:0]               rd_word,
    output logic [NBLK-1:0]           locked
);
    localparam int DEPTH = 1 << AW;

    logic [15:0] mem [DEPTH];

    assign locked  = LOCK_INIT;
    assign rd_word = mem[rd_addr];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam logic [AW-1:0] WA = AW'(w);
        always_ff @(posedge clk) begin
            if (rst)
                mem[w] <= INIT_WORD;
            else if (erase_go && (WA[AW-1:BLK_W] == erase_blk))
                mem[w] <= 16'hFFFF;
        end
    end

    AST_NO_LOCKED_ERASE: assert property (@(posedge clk) disable iff (rst)
        erase_go |-> !locked[erase_blk]);                             // R12

endmodule

// File: rtl/fcmd_decode.sv
module fcmd_decode
    import fcmd_pkg::*;
#(
    parameter int BIW  = 2,
    parameter int NBLK = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pwrdn,
    input  logic            wr_en,
    input  logic [7:0]      wr_cmd,
    input  logic [BIW-1:0]  blk,
    input  logic            rd_n,
    input  logic [NBLK-1:0] locked,
    input  logic            running,
    input  logic            paused,
    output rd_src_e         src,
    output logic            start,
    output logic            pause_req,
    output logic            resume_req,
    output logic [7:0]      stat_held
);
    rd_src_e src_nxt;
    sticky_t sticky, set_bits;
    logic    pend, pend_nxt, clr, busy, rd_prev;
    logic [7:0] stat_live;

    assign busy      = running && !paused;
    assign stat_live = pack_status(!busy, paused, sticky);

    always_comb begin
        src_nxt    = src;
        pend_nxt   = pend;
        start      = 1'b0;
        pause_req  = 1'b0;
        resume_req = 1'b0;
        clr        = 1'b0;
        set_bits   = '0;
        if (pwrdn) begin
            src_nxt  = SRC_ARRAY;
            pend_nxt = 1'b0;
        end else if (wr_en) begin
            pend_nxt = 1'b0;
            if (pend) begin
                src_nxt = SRC_STATUS;
                if (wr_cmd == CMD_CONFIRM) begin
                    if (locked[blk]) set_bits.lock_fail = 1'b1;
                    else             start = 1'b1;
                end else begin
                    set_bits.seq_fail   = 1'b1;
                    set_bits.erase_fail = 1'b1;
                end
            end else begin
                case (wr_cmd)
                    CMD_RD_ARRAY: if (!busy) src_nxt = SRC_ARRAY;
                    CMD_RD_IDENT: src_nxt = SRC_IDENT;
                    CMD_RD_STAT:  src_nxt = SRC_STATUS;
                    CMD_CLR_STAT: if (!paused) clr = 1'b1;
                    CMD_ER_SETUP: if (!running) begin
                        pend_nxt = 1'b1;
                        src_nxt  = SRC_STATUS;
                    end
                    CMD_SUSPEND: if (busy) begin
                        pause_req = 1'b1;
                        src_nxt   = SRC_STATUS;
                    end
                    CMD_CONFIRM: begin
                        if (paused) resume_req = 1'b1;
                        src_nxt = SRC_STATUS;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src       <= SRC_ARRAY;
            pend      <= 1'b0;
            sticky    <= '0;
            rd_prev   <= 1'b1;
            stat_held <= 8'h80;
        end else begin
            src     <= src_nxt;
            pend    <= pend_nxt;
            sticky  <= clr ? sticky_t'('0) : (sticky | set_bits);
            rd_prev <= rd_n;
            if (!rd_n && rd_prev) stat_held <= stat_live;
        end
    end

    AST_ARRAY_REFUSED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!pwrdn && wr_en && !pend && wr_cmd == CMD_RD_ARRAY && busy)
        |=> $stable(src));                                            // R3
    AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!pwrdn && !wr_en) |=> $stable(src));                         // R2
    AST_STICKY_ONLY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_cmd == CMD_CLR_STAT)
        |=> ((sticky & $past(sticky)) == $past(sticky)));             // R6
    AST_CLEAR_REFUSED_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (!pwrdn && wr_en && !pend && wr_cmd == CMD_CLR_STAT && paused)
        |=> $stable(sticky));                                         // R7
    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !rd_prev) |=> $stable(stat_held));                  // R10

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int AW                 = 6,
    parameter int BLK_W              = 4,
    parameter int ERASE_CYC          = 40,
    parameter logic [15:0] INIT_WORD = 16'h1234,
    parameter logic [3:0] LOCK_INIT  = 4'b0010,
    parameter logic PERM_LOCK        = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwrdn,
    input  logic          wr_en,
    input  logic [7:0]    wr_cmd,
    input  logic [AW-1:0] addr,
    input  logic          rd_n,
    output logic [15:0]   rdata
);
    localparam int BIW  = AW - BLK_W;
    localparam int NBLK = 1 << BIW;

    rd_src_e         src;
    logic            start, pause_req, resume_req;
    logic            running, paused, done;
    logic [BIW-1:0]  done_blk;
    logic [NBLK-1:0] locked;
    logic [15:0]     arr_word, id_word;
    logic [7:0]      stat_held;
    logic [BLK_W-1:0] offs;

    assign offs = addr[BLK_W-1:0];

    fcmd_decode #(.BIW(BIW), .NBLK(NBLK)) u_dec (
        .clk(clk), .rst(rst), .pwrdn(pwrdn), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .blk(addr[AW-1:BLK_W]), .rd_n(rd_n), .locked(locked),
        .running(running), .paused(paused), .src(src), .start(start),
        .pause_req(pause_req), .resume_req(resume_req), .stat_held(stat_held)
    );

    fcmd_wsm #(.ERASE_CYC(ERASE_CYC), .BIW(BIW)) u_wsm (
        .clk(clk), .rst(rst), .start(start), .start_blk(addr[AW-1:BLK_W]),
        .pause_req(pause_req), .resume_req(resume_req), .running(running),
        .paused(paused), .done(done), .done_blk(done_blk)
    );

    fcmd_store #(.AW(AW), .BLK_W(BLK_W), .INIT_WORD(INIT_WORD),
                 .NBLK(NBLK), .LOCK_INIT(NBLK'(LOCK_INIT))) u_store (
        .clk(clk), .rst(rst), .erase_go(done), .erase_blk(done_blk),
        .rd_addr(addr), .rd_word(arr_word), .locked(locked)
    );

    always_comb begin
        id_word = 16'h0000;
        if (addr == AW'(0))            id_word = ID_MAKER;
        else if (addr == AW'(1))       id_word = ID_DEVICE;
        else if (offs == BLK_W'(2))    id_word = {15'b0, locked[addr[AW-1:BLK_W]]};
        else if (offs == BLK_W'(3))    id_word = {15'b0, PERM_LOCK};
    end

    always_comb begin
        case (src)
            SRC_IDENT:  rdata = id_word;
            SRC_STATUS: rdata = {8'h00, stat_held};
            default:    rdata = arr_word;
        endcase
    end

endmodule

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwrdn = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_cmd = 8'h00;
    logic [AW-1:0] addr = '0;
    logic          rd_n = 1'b1;
    logic [15:0]   rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];
    event        smp_ev;

    always #10 clk = ~clk;

    flash_cmd_ctrl uut (
        .clk(clk), .rst(rst), .pwrdn(pwrdn), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .addr(addr), .rd_n(rd_n), .rdata(rdata)
    );

    // monitor: pops expected items and compares them with the port
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rdata !== e) begin
                    failures++;
                    $display("FAIL %s: got %h expected %h", t, rdata, e);
                end
            end
        end
    end

    task automatic put_cmd(input logic [7:0] c, input logic [AW-1:0] a);
        @(negedge clk);
        wr_cmd = c; addr = a; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: strobes a read, queues the expected value, triggers the monitor
    task automatic rd_chk(input logic [AW-1:0] a, input int hold,
                          input logic [15:0] e, input string t);
        @(negedge clk);
        addr = a; rd_n = 1'b0;
        repeat (hold) @(posedge clk);
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        #2 ->smp_ev;
        @(negedge clk);
        rd_n = 1'b1;
    endtask

    task automatic wait_ready();
        bit rdy = 0;
        for (int i = 0; i < 1000 && !rdy; i++) begin
            @(negedge clk); rd_n = 1'b0;
            @(posedge clk); #2 rdy = rdata[7];
            @(negedge clk); rd_n = 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        rd_chk(6'h05, 0, 16'h1234, "R1 reset array read");
        rd_chk(6'h3F, 0, 16'h1234, "R2 array persists");

        put_cmd(8'h90, 6'h00);
        rd_chk(6'h00, 0, 16'h00B0, "R4 maker code");
        rd_chk(6'h01, 0, 16'h0050, "R4 device code");
        rd_chk(6'h12, 0, 16'h0001, "R5 block1 locked");
        rd_chk(6'h02, 0, 16'h0000, "R5 block0 unlocked");
        rd_chk(6'h13, 0, 16'h0000, "R5 permanent lock");
        rd_chk(6'h22, 0, 16'h0000, "R2 ident persists");

        put_cmd(8'h70, 6'h00);
        rd_chk(6'h00, 0, 16'h0080, "R11 ready idle");

        put_cmd(8'h20, 6'h20);
        put_cmd(8'h70, 6'h20);
        rd_chk(6'h00, 0, 16'h00B0, "R9 sequence error bits");
        put_cmd(8'hFF, 6'h00);
        rd_chk(6'h25, 0, 16'h1234, "R9 no erase after bad sequence");
        put_cmd(8'h90, 6'h00);
        put_cmd(8'h70, 6'h00);
        rd_chk(6'h00, 0, 16'h00B0, "R6 sticky survives commands");

        put_cmd(8'h20, 6'h10);
        put_cmd(8'hD0, 6'h10);
        rd_chk(6'h00, 0, 16'h00B2, "R12 lock error bit");
        put_cmd(8'hFF, 6'h00);
        rd_chk(6'h10, 0, 16'h1234, "R12 locked block unchanged");
        rd_chk(6'h1F, 0, 16'h1234, "R12 locked block unchanged end");

        put_cmd(8'h20, 6'h25);
        put_cmd(8'hD0, 6'h25);
        rd_chk(6'h00, 0, 16'h0032, "R11 busy status");
        put_cmd(8'hFF, 6'h00);
        rd_chk(6'h25, 0, 16'h0032, "R3 array refused while busy");
        put_cmd(8'hB0, 6'h00);
        rd_chk(6'h00, 0, 16'h00F2, "R11 paused status");
        repeat (100) @(posedge clk);
        rd_chk(6'h00, 0, 16'h00F2, "R11 timer frozen while paused");
        put_cmd(8'h50, 6'h00);
        rd_chk(6'h00, 0, 16'h00F2, "R7 clear refused while paused");
        put_cmd(8'hFF, 6'h00);
        rd_chk(6'h25, 0, 16'h1234, "R3 array accepted while paused");
        put_cmd(8'hD0, 6'h00);
        wait_ready();
        rd_chk(6'h00, 0, 16'h00B2, "R8 erase completes after resume");
        put_cmd(8'h50, 6'h00);
        rd_chk(6'h00, 0, 16'h0080, "R6 clear command");
        put_cmd(8'hFF, 6'h00);
        rd_chk(6'h20, 0, 16'hFFFF, "R8 block2 first word");
        rd_chk(6'h2F, 0, 16'hFFFF, "R8 block2 last word");
        rd_chk(6'h25, 0, 16'hFFFF, "R8 block2 middle word");
        rd_chk(6'h30, 0, 16'h1234, "R8 block3 untouched");
        rd_chk(6'h1F, 0, 16'h1234, "R8 block1 untouched");

        put_cmd(8'h20, 6'h35);
        put_cmd(8'hD0, 6'h35);
        rd_chk(6'h00, 60, 16'h0000, "R10 held status frozen");
        rd_chk(6'h00, 0, 16'h0080, "R10 fresh capture");

        @(negedge clk) pwrdn = 1'b1;
        put_cmd(8'h70, 6'h00);
        @(negedge clk) pwrdn = 1'b0;
        rd_chk(6'h35, 0, 16'hFFFF, "R1 array after power-down");

        repeat (3) @(posedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule